// File: doc/BRIEF.md
# Board-Variant Display Configuration and Card Slot Status Registers

This block is a small register slice that a system controller places on its 32-bit register port. It holds a display-configuration word and a read-only card slot status word. A static 32-bit identity parameter carries a 12-bit board-variant code in bits [27:16]. That code fixes three things at elaboration: which bits of the display word software may change, the value the display word takes at reset, and whether a 2-bit panel-format select output is driven.

The two card slot inputs are a card-present pin and a write-protect pin. They are asynchronous to the register clock, so they pass through a flop synchroniser before they appear as status bits. The bit position of the write-protect flag depends on the variant.

Accesses are single-cycle. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. A read returns data combinationally while `bus_sel` is high and `bus_wr` is low. At all other times `bus_rdata` is zero. The control and status pins are plain levels.

Top module: `disp_card_regs`

## Requirements
- R1: The variant code is bits [27:16] of `ID_WORD`. Out of reset, the display word at byte offset 0x50 reads 0x0000_1F00 (a VGA panel identity), except for code 0x190, where it reads 0. `panel_mux_o` resets to 0.
- R2: For codes 0x100 and 0x140, a write to 0x50 leaves bits [13:8] unchanged and loads every other bit from `bus_wdata`.
- R3: For codes 0x178 and 0x182, a write to 0x50 updates only bit 7 and keeps all other bits.
- R4: For code 0x190, the display word always reads 0 and writes to it are ignored. For any code not listed in R2, R3 or here, writes to it are also ignored and it keeps its reset value.
- R5: For code 0x100 only, a write to 0x50 drives `bus_wdata[1:0]` onto `panel_mux_o` from the accepting clock edge onward. The output holds between such writes. It stays 0 for every other code.
- R6: Bit 0 of the status word at byte offset 0x48 follows `card_present_i`. A change on the pin is visible after exactly two rising clock edges.
- R7: `card_wprot_i` drives bit 2 of the status word for codes 0x100 and 0x140, and bit 1 for all other codes. It has the same two-edge latency as R6. All other status bits read 0.
- R8: Writes to 0x48 do not change the status word. Reads from unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while a read is selected |
| card_present_i | input | 1 | Card detect pin, asynchronous |
| card_wprot_i | input | 1 | Card write-protect pin, asynchronous |
| panel_mux_o | output | 2 | Registered panel-format select |

## Verification
Expected latencies:
- A display write is visible on the read port, and on `panel_mux_o`, after the single edge that accepts it.
- A read result is due in the same cycle as the read request.
- A pin change reaches the status word after two edges.

The bench drives every input on a falling edge. It samples read data one time unit after driving the read. For the pin tests, it reads once after one rising edge, expecting the old value, and again after the second rising edge, expecting the new one. This pins the synchroniser latency exactly. Each of the four variant classes gets its own instance with its own select, so a write aimed at one instance cannot disturb another.

// File: rtl/disp_status_pkg.sv
package disp_status_pkg;

  typedef enum logic [1:0] {
    VAR_MUXED     = 2'd0,
    VAR_RO_FIELD  = 2'd1,
    VAR_BIT7_ONLY = 2'd2,
    VAR_FROZEN    = 2'd3
  } disp_variant_e;

  localparam logic [11:0] CODE_MUXED  = 12'h100;
  localparam logic [11:0] CODE_RO     = 12'h140;
  localparam logic [11:0] CODE_B7_A   = 12'h178;
  localparam logic [11:0] CODE_B7_B   = 12'h182;
  localparam logic [11:0] CODE_BLANK  = 12'h190;

  localparam logic [31:0] PANEL_ID_RESET = 32'h0000_1F00;
  localparam logic [31:0] RO_FIELD_MASK  = 32'h0000_3F00;
  localparam logic [31:0] BIT7_MASK      = 32'h0000_0080;

  function automatic disp_variant_e classify(input logic [11:0] code);
    case (code)
      CODE_MUXED:           return VAR_MUXED;
      CODE_RO:              return VAR_RO_FIELD;
      CODE_B7_A, CODE_B7_B: return VAR_BIT7_ONLY;
      default:              return VAR_FROZEN;
    endcase
  endfunction

  function automatic int unsigned wprot_pos(input logic [11:0] code);
    return (code == CODE_MUXED || code == CODE_RO) ? 2 : 1;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic             started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
      end
      // R6
      first_stage_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> stage_q[0] == $past(din));
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
      // R7
      stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> stage_q[s] == $past(stage_q[s-1]));
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/disp_cfg_reg.sv
module disp_cfg_reg
  import disp_status_pkg::*;
#(
  parameter int            DATA_W    = 32,
  parameter disp_variant_e VARIANT   = VAR_MUXED,
  parameter logic [31:0]   RESET_VAL = PANEL_ID_RESET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] disp_q,
  output logic [1:0]        mux_q
);

  localparam logic [DATA_W-1:0] RST_W   = DATA_W'(RESET_VAL);
  localparam logic [DATA_W-1:0] RO_W    = DATA_W'(RO_FIELD_MASK);
  localparam logic [DATA_W-1:0] B7_W    = DATA_W'(BIT7_MASK);

  logic [DATA_W-1:0] disp_d;

  if (VARIANT == VAR_MUXED || VARIANT == VAR_RO_FIELD) begin : g_ro_field
    assign disp_d = (disp_q & RO_W) | (wdata & ~RO_W);
    // R2
    ro_field_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> disp_q[13:8] == $past(disp_q[13:8]));
  end else if (VARIANT == VAR_BIT7_ONLY) begin : g_bit7
    assign disp_d = (disp_q & ~B7_W) | (wdata & B7_W);
    // R3
    bit7_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (disp_q & ~B7_W) == ($past(disp_q) & ~B7_W));
  end else begin : g_frozen
    assign disp_d = disp_q;
    // R4
    frozen_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> $stable(disp_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      disp_q <= RST_W;
    else if (wr_hit) disp_q <= disp_d;
  end

  if (VARIANT == VAR_MUXED) begin : g_mux
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mux_q <= 2'b00;
      else if (wr_hit) mux_q <= wdata[1:0];
    end
    // R5
    mux_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> mux_q == $past(wdata[1:0]));
    // R5
    mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(mux_q));
  end else begin : g_no_mux
    assign mux_q = 2'b00;
  end

endmodule

// File: rtl/card_status.sv
module card_status #(
  parameter int DATA_W = 32,
  parameter int WP_BIT = 2
) (
  input  logic              present_s,
  input  logic              wprot_s,
  output logic [DATA_W-1:0] status_w
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == 0) begin : g_det
      assign status_w[b] = present_s;
    end else if (b == WP_BIT) begin : g_wp
      assign status_w[b] = wprot_s;
    end else begin : g_zero
      assign status_w[b] = 1'b0;
    end
  end

endmodule

// File: rtl/disp_card_regs.sv
module disp_card_regs
  import disp_status_pkg::*;
#(
  parameter logic [31:0] ID_WORD     = 32'h0100_0000,
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          SYNC_STAGES = 2,
  parameter int          OFF_DISP    = 'h50,
  parameter int          OFF_CARD    = 'h48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              card_present_i,
  input  logic              card_wprot_i,
  output logic [1:0]        panel_mux_o
);

  localparam logic [11:0]   VCODE   = ID_WORD[27:16];
  localparam disp_variant_e VARIANT = classify(VCODE);
  localparam logic [31:0]   RST_VAL = (VCODE == CODE_BLANK) ? 32'h0 : PANEL_ID_RESET;
  localparam int            WP_BIT  = wprot_pos(VCODE);
  localparam logic [ADDR_W-1:0] A_DISP = ADDR_W'(OFF_DISP);
  localparam logic [ADDR_W-1:0] A_CARD = ADDR_W'(OFF_CARD);

  logic              disp_wr;
  logic [DATA_W-1:0] disp_q;
  logic [DATA_W-1:0] card_w;
  logic [1:0]        pins_s;

  assign disp_wr = bus_sel && bus_wr && (bus_addr == A_DISP);

  disp_cfg_reg #(
    .DATA_W   (DATA_W),
    .VARIANT  (VARIANT),
    .RESET_VAL(RST_VAL)
  ) u_disp (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_hit(disp_wr),
    .wdata (bus_wdata),
    .disp_q(disp_q),
    .mux_q (panel_mux_o)
  );

  pin_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({card_wprot_i, card_present_i}),
    .dout (pins_s)
  );

  card_status #(
    .DATA_W(DATA_W),
    .WP_BIT(WP_BIT)
  ) u_card (
    .present_s(pins_s[0]),
    .wprot_s  (pins_s[1]),
    .status_w (card_w)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == A_DISP)      bus_rdata = disp_q;
      else if (bus_addr == A_CARD) bus_rdata = card_w;
    end
  end

  // R8
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0);

endmodule

// File: tb/test_disp_card_regs.sv
module test_disp_card_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NV = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NI-1:0] sel = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        pres = 1'b0;
  logic        wprot = 1'b0;
  logic [31:0] rd [NI];
  logic [1:0]  mux [NI];

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // instance 0: code 0x100, 1: 0x182, 2: 0x140, 3: 0x190
  disp_card_regs #(.ID_WORD(32'h0100_0000)) i_disp_card_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[0]), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd[0]), .card_present_i(pres),
    .card_wprot_i(wprot), .panel_mux_o(mux[0]));
  disp_card_regs #(.ID_WORD(32'h0182_0000)) i_disp_card_regs_b7 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[1]), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd[1]), .card_present_i(pres),
    .card_wprot_i(wprot), .panel_mux_o(mux[1]));
  disp_card_regs #(.ID_WORD(32'h0140_0000)) i_disp_card_regs_ro (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[2]), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd[2]), .card_present_i(pres),
    .card_wprot_i(wprot), .panel_mux_o(mux[2]));
  disp_card_regs #(.ID_WORD(32'h0190_0000)) i_disp_card_regs_fz (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[3]), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd[3]), .card_present_i(pres),
    .card_wprot_i(wprot), .panel_mux_o(mux[3]));

  // vector table for the 0x100 instance: write, then read back
  localparam logic [7:0]  T_WADDR [NV] = '{8'h50, 8'h50, 8'h50, 8'h48, 8'h60, 8'h50};
  localparam logic [31:0] T_WDATA [NV] = '{32'hFFFF_FFFF, 32'h0000_0002, 32'h1234_00C1,
                                           32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_3F00};
  localparam logic [7:0]  T_RADDR [NV] = '{8'h50, 8'h50, 8'h50, 8'h48, 8'h60, 8'h50};
  localparam logic [31:0] T_EXP   [NV] = '{32'hFFFF_DFFF, 32'h0000_1F02, 32'h1234_1FC1,
                                           32'h0000_0000, 32'h0000_0000, 32'h0000_1F00};
  localparam logic [1:0]  T_MUX   [NV] = '{2'd3, 2'd2, 2'd1, 2'd1, 2'd1, 2'd0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input int idx, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = '0; sel[idx] = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = '0; wr = 1'b0;
  endtask

  task automatic read_chk(input int idx, input logic [7:0] a, input logic [31:0] exp,
                          input string req);
    sel = '0; sel[idx] = 1'b1; wr = 1'b0; addr = a;
    #1;
    check(req, rd[idx], exp);
    sel = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values per variant
    read_chk(0, 8'h50, 32'h0000_1F00, "R1 reset 0x100");
    read_chk(1, 8'h50, 32'h0000_1F00, "R1 reset 0x182");
    read_chk(2, 8'h50, 32'h0000_1F00, "R1 reset 0x140");
    read_chk(3, 8'h50, 32'h0000_0000, "R1 reset 0x190");
    check("R1 mux reset", {30'd0, mux[0]}, 32'd0);

    // R2 R5 R8 table walk on the 0x100 instance
    for (int i = 0; i < NV; i++) begin
      do_write(0, T_WADDR[i], T_WDATA[i]);
      read_chk(0, T_RADDR[i], T_EXP[i], "R2/R8 table read");
      check("R5 mux after write", {30'd0, mux[0]}, {30'd0, T_MUX[i]});
    end

    // R5 hold across idle cycles
    repeat (3) @(negedge clk);
    check("R5 mux hold", {30'd0, mux[0]}, 32'd0);

    // R3 bit 7 only
    do_write(1, 8'h50, 32'hFFFF_FFFF);
    read_chk(1, 8'h50, 32'h0000_1F80, "R3 set bit7");
    do_write(1, 8'h50, 32'h0000_0000);
    read_chk(1, 8'h50, 32'h0000_1F00, "R3 clear bit7");

    // R2 and R5 on 0x140: masked write, no mux
    do_write(2, 8'h50, 32'hA5A5_A5A7);
    read_chk(2, 8'h50, 32'hA5A5_9FA7, "R2 0x140 write");
    check("R5 no mux on 0x140", {30'd0, mux[2]}, 32'd0);
    check("R5 no mux on 0x182", {30'd0, mux[1]}, 32'd0);

    // R4 frozen variant
    do_write(3, 8'h50, 32'hFFFF_FFFF);
    read_chk(3, 8'h50, 32'h0000_0000, "R4 0x190 ignores write");

    // R6 card detect with two-edge latency
    @(negedge clk);
    pres = 1'b1;
    @(negedge clk);
    read_chk(0, 8'h48, 32'h0000_0000, "R6 after one edge");
    @(negedge clk);
    read_chk(0, 8'h48, 32'h0000_0001, "R6 after two edges");

    // R7 write-protect position per variant
    wprot = 1'b1;
    @(negedge clk);
    read_chk(0, 8'h48, 32'h0000_0001, "R7 after one edge");
    @(negedge clk);
    read_chk(0, 8'h48, 32'h0000_0005, "R7 0x100 bit2");
    read_chk(2, 8'h48, 32'h0000_0005, "R7 0x140 bit2");
    read_chk(1, 8'h48, 32'h0000_0003, "R7 0x182 bit1");
    read_chk(3, 8'h48, 32'h0000_0003, "R7 0x190 bit1");

    // R8 status is read-only
    do_write(1, 8'h48, 32'h0000_0000);
    read_chk(1, 8'h48, 32'h0000_0003, "R8 status write ignored");

    // R6 falling edge of card detect
    pres = 1'b0;
    wprot = 1'b0;
    repeat (2) @(negedge clk);
    read_chk(0, 8'h48, 32'h0000_0000, "R6 pins released");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule